// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of signed temperature results and drives one alert pin from them. Each time a conversion finishes, the new result is compared with a programmable upper limit and a programmable lower limit. A run of consecutive qualifying results, of a length chosen by a 2-bit field, is needed before the alert changes. Isolated noisy samples therefore never reach the pin.

There are two modes. In comparator mode the alert follows the temperature with hysteresis. It turns on once results reach the upper limit and turns off only once they drop under the lower limit. In interrupt mode the alert is a latched event that stays on until the host clears it. The host clears it with a register read, an acknowledged alert-response cycle, or a shutdown request. The trigger condition then alternates between the upper and the lower limit, so that each crossing gives one event.

A general-call reset returns the block to comparator mode with everything cleared. A configuration write that changes the mode also restarts the block. The pin polarity can be selected.

Top module: `temp_alert_ctrl`

## Requirements
- R1: Temperature and both limits are 12-bit two's complement values compared as signed numbers. The high condition is temp >= lim_hi. The low condition is temp < lim_lo.
- R2: In comparator mode (mode 0) the alert turns on after the required run of high-condition conversions. It turns off after the required run of low-condition conversions. Between those events it holds its state.
- R3: fq_sel values 0, 1, 2 and 3 require runs of 1, 2, 4 and 6 consecutive conversions. A conversion that meets the watched condition advances the run. A conversion that does not meet it restarts the run from zero. With no conversion, the run holds.
- R4: In interrupt mode (mode 1) the alert turns on after the required run of high-condition conversions. It then stays on until a host clear.
- R5: In interrupt mode, a reg_rd, ara_ack or shutdown pulse clears a pending alert. In comparator mode these pulses have no effect on the alert.
- R6: In interrupt mode the watched condition alternates. After each event has fired, the next event needs a run of the opposite condition: low after high, then high after low.
- R7: While an interrupt-mode alert is pending, conversions are not evaluated. A run after the clear starts from zero.
- R8: With pol = 0 the alert_out pin is low when active and high when inactive. With pol = 1 the pin is high when active. Out of reset the alert is inactive.
- R9: A gc_reset pulse clears the alert and the run counter, returns the watched condition to high, and forces comparator mode.
- R10: A cfg_wr pulse whose cfg_int_mode differs from the current mode switches to that mode, clears the alert and the run counter, and returns to watching the high condition. A cfg_wr pulse that does not change the mode has no effect.
- R11: The alert changes at the clock edge that samples the conversion completing the run. It is visible at the pin right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new temperature result is valid |
| temp | input | 12 | Signed temperature result |
| lim_hi | input | 12 | Signed upper limit |
| lim_lo | input | 12 | Signed lower limit |
| fq_sel | input | 2 | Consecutive-run length select |
| pol | input | 1 | Pin polarity: 1 = active high |
| cfg_wr | input | 1 | Configuration write pulse carrying the mode bit |
| cfg_int_mode | input | 1 | Mode value written: 0 comparator, 1 interrupt |
| reg_rd | input | 1 | Pulse: a register was read |
| ara_ack | input | 1 | Pulse: alert-response reply succeeded |
| shutdown | input | 1 | Pulse: entry into shutdown |
| gc_reset | input | 1 | Pulse: general-call reset |
| alert_out | output | 1 | Alert pin |

## Verification
Several properties are checked on every clock by the assertions. In comparator mode the watched condition tracks the alert state. A pending interrupt alert survives until a clear, a reset or a mode change. The run counter only steps up by one or drops to zero. The alert never rises without a completed run, and host pulses leave the comparator-mode alert untouched.

Other behaviour can only be shown by the bench scenarios. These include the exact run lengths for each fq_sel value, the signed comparison across the whole 12-bit range, the high/low alternation of interrupt events, and the pin level under both polarities. The bench checks them against its own model of the requirements.

// File: rtl/tac_pkg.sv
package tac_pkg;

  localparam int FQ_W  = 2;
  localparam int CNT_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    WATCH_HI = 1'b0,
    WATCH_LO = 1'b1
  } watch_e;

  // run length demanded by the fault-count select
  function automatic cnt_t fq_need(input logic [FQ_W-1:0] sel);
    cnt_t n;
    case (sel)
      2'd0:    n = cnt_t'(1);
      2'd1:    n = cnt_t'(2);
      2'd2:    n = cnt_t'(4);
      default: n = cnt_t'(6);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tac_limit_cmp.sv
module tac_limit_cmp #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] t_val,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  output logic          hi_hit,
  output logic          lo_hit
);

  always_comb begin
    hi_hit = ($signed(t_val) >= $signed(hi_lim));
    lo_hit = ($signed(t_val) <  $signed(lo_lim));
  end

endmodule

// File: rtl/tac_fault_filter.sv
module tac_fault_filter
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic sample,
  input  logic met,
  input  cnt_t need,
  output logic fire
);

  cnt_t           cnt_q;
  logic [CNT_W:0] cnt_nxt;

  always_comb begin
    cnt_nxt = {1'b0, cnt_q} + 1'b1;
    fire    = sample && met && (cnt_nxt >= {1'b0, need});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (flush || fire || (sample && !met))
      cnt_q <= '0;
    else if (sample && met)
      cnt_q <= cnt_nxt[CNT_W-1:0];
  end

  // R3: the run counter only climbs by one or restarts at zero
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

  // R3: without a strobe or flush the run is frozen
  p_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !flush) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/tac_alert_fsm.sv
module tac_alert_fsm
  import tac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gc_rst,
  input  logic   cfg_wr,
  input  logic   cfg_int,
  input  logic   rd_evt,
  input  logic   ara_evt,
  input  logic   shdn_evt,
  input  logic   fire,
  output logic   alert_q,
  output watch_e watch_q,
  output logic   mode_q,
  output logic   eval_en,
  output logic   mode_chg
);

  logic host_clr;

  always_comb begin
    mode_chg = cfg_wr && (cfg_int != mode_q);
    host_clr = mode_q && (rd_evt || ara_evt || shdn_evt);
    eval_en  = !(mode_q && alert_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      watch_q <= WATCH_HI;
      mode_q  <= 1'b0;
    end else if (gc_rst) begin
      alert_q <= 1'b0;
      watch_q <= WATCH_HI;
      mode_q  <= 1'b0;
    end else if (mode_chg) begin
      alert_q <= 1'b0;
      watch_q <= WATCH_HI;
      mode_q  <= cfg_int;
    end else if (fire) begin
      watch_q <= (watch_q == WATCH_HI) ? WATCH_LO : WATCH_HI;
      alert_q <= mode_q ? 1'b1 : !alert_q;
    end else if (host_clr) begin
      alert_q <= 1'b0;
    end
  end

  // R2: in comparator mode the low condition is watched exactly while active
  p_cmp_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> ((watch_q == WATCH_LO) == alert_q));

  // R4: a pending interrupt alert persists until cleared
  p_int_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && alert_q && !rd_evt && !ara_evt && !shdn_evt && !gc_rst && !mode_chg)
      |=> alert_q);

  // R5: host pulses never move the comparator-mode alert
  p_cmp_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !fire && !gc_rst && !mode_chg) |=> $stable(alert_q));

  // R9: general-call reset leaves an idle comparator
  p_gc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gc_rst |=> (!alert_q && !mode_q && watch_q == WATCH_HI));

  // R10: a mode change restarts on the high condition
  p_mode_chg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !gc_rst) |=> (!alert_q && watch_q == WATCH_HI && mode_q == $past(cfg_int)));

  // R11: the alert only rises on a completed run
  p_rise_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_q) |-> $past(fire));

endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import tac_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [FQ_W-1:0]   fq_sel,
  input  logic              pol,
  input  logic              cfg_wr,
  input  logic              cfg_int_mode,
  input  logic              reg_rd,
  input  logic              ara_ack,
  input  logic              shutdown,
  input  logic              gc_reset,
  output logic              alert_out
);

  logic   hi_hit, lo_hit, met, fire, flush;
  logic   alert_q, mode_q, eval_en, mode_chg, sample;
  watch_e watch_q;
  cnt_t   need;

  tac_limit_cmp #(.TW(TEMP_W)) u_cmp (
    .t_val  (temp),
    .hi_lim (lim_hi),
    .lo_lim (lim_lo),
    .hi_hit (hi_hit),
    .lo_hit (lo_hit)
  );

  always_comb begin
    met    = (watch_q == WATCH_LO) ? lo_hit : hi_hit;
    need   = fq_need(fq_sel);
    sample = conv_done && eval_en;
    flush  = gc_reset || mode_chg;
  end

  tac_fault_filter u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .sample (sample),
    .met    (met),
    .need   (need),
    .fire   (fire)
  );

  tac_alert_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .gc_rst   (gc_reset),
    .cfg_wr   (cfg_wr),
    .cfg_int  (cfg_int_mode),
    .rd_evt   (reg_rd),
    .ara_evt  (ara_ack),
    .shdn_evt (shutdown),
    .fire     (fire),
    .alert_q  (alert_q),
    .watch_q  (watch_q),
    .mode_q   (mode_q),
    .eval_en  (eval_en),
    .mode_chg (mode_chg)
  );

  assign alert_out = pol ? alert_q : !alert_q;

  // R7: a pending interrupt alert blocks evaluation, so no run completes
  p_pending_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && alert_q) |-> !fire);

endmodule

// File: tb/sim_temp_alert_ctrl.sv
module sim_temp_alert_ctrl;

  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv_done = 1'b0;
  logic signed [11:0] temp = '0;
  logic signed [11:0] lim_hi = 12'sd40;
  logic signed [11:0] lim_lo = -12'sd20;
  logic [1:0]        fq_sel = 2'd0;
  logic              pol = 1'b0;
  logic              cfg_wr = 1'b0;
  logic              cfg_int_mode = 1'b0;
  logic              reg_rd = 1'b0;
  logic              ara_ack = 1'b0;
  logic              shutdown = 1'b0;
  logic              gc_reset = 1'b0;
  logic              alert_out;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  bit m_alert = 0;
  bit m_wlo   = 0;
  bit m_mode  = 0;
  int m_run   = 0;
  bit [31:0] rs = 32'h1234_abcd;

  always #(CLK_P/2) clk = ~clk;

  temp_alert_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .fq_sel(fq_sel), .pol(pol),
    .cfg_wr(cfg_wr), .cfg_int_mode(cfg_int_mode), .reg_rd(reg_rd),
    .ara_ack(ara_ack), .shutdown(shutdown), .gc_reset(gc_reset),
    .alert_out(alert_out)
  );

  function automatic int run_len(input logic [1:0] s);
    return (s == 2'd3) ? 6 : (1 << s);
  endfunction

  function automatic bit [31:0] nxt(input bit [31:0] v);
    bit [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag);
    logic want;
    want = pol ? m_alert : !m_alert;
    n_cmp++;
    if (alert_out !== want) begin
      n_bad++;
      $display("FAIL %s: alert_out=%b expected %b at %0t", tag, alert_out, want, $time);
    end
  endtask

  task automatic conv(input logic signed [11:0] t, input string tag);
    bit hit;
    conv_done = 1'b1; temp = t;
    @(negedge clk);
    conv_done = 1'b0;
    if (!(m_mode && m_alert)) begin
      hit = m_wlo ? (t < lim_lo) : (t >= lim_hi);
      if (hit) begin
        m_run++;
        if (m_run >= run_len(fq_sel)) begin
          m_run = 0;
          m_wlo = !m_wlo;
          m_alert = m_mode ? 1'b1 : !m_alert;
        end
      end else m_run = 0;
    end
    chk(tag);
  endtask

  // kind: 0 read, 1 alert-response ack, 2 shutdown
  task automatic host(input int kind, input string tag);
    reg_rd = (kind == 0); ara_ack = (kind == 1); shutdown = (kind == 2);
    @(negedge clk);
    reg_rd = 0; ara_ack = 0; shutdown = 0;
    if (m_mode) m_alert = 0;
    chk(tag);
  endtask

  task automatic gcr(input string tag);
    gc_reset = 1'b1;
    @(negedge clk);
    gc_reset = 1'b0;
    m_alert = 0; m_wlo = 0; m_mode = 0; m_run = 0;
    chk(tag);
  endtask

  task automatic wr_mode(input bit v, input string tag);
    cfg_wr = 1'b1; cfg_int_mode = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (v != m_mode) begin
      m_mode = v; m_alert = 0; m_wlo = 0; m_run = 0;
    end
    chk(tag);
  endtask

  task automatic set_pol(input bit v);
    pol = v;
    #1 chk("R8");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8");            // reset: inactive, pin high with pol 0
    set_pol(1); set_pol(0);

    // R1: full signed sweep in comparator mode, run length 1
    for (int p = 0; p < 3; p++) begin
      gcr("R9");
      lim_hi = (p == 0) ? 12'sd100 : (p == 1) ? -12'sd50  : 12'sd2047;
      lim_lo = (p == 0) ? -12'sd100 : (p == 1) ? -12'sd300 : -12'sd2048;
      for (int t = -2048; t < 2048; t++) conv(12'(t), "R1");
    end
    lim_hi = 12'sd40; lim_lo = -12'sd20;

    // run length, hysteresis and interrupt cycle per select value
    for (int f = 0; f < 4; f++) begin
      gcr("R9");
      fq_sel = 2'(f);
      for (int i = 0; i < run_len(fq_sel) - 1; i++) conv(12'sd40, "R3");
      conv(12'sd0, "R3");
      for (int i = 0; i < run_len(fq_sel); i++) conv(12'sd41, "R11");
      conv(12'sd10, "R2");
      host(0, "R5"); host(2, "R5"); host(1, "R5");
      for (int i = 0; i < run_len(fq_sel) - 1; i++) conv(-12'sd21, "R2");
      conv(-12'sd20, "R2");
      for (int i = 0; i < run_len(fq_sel); i++) conv(-12'sd21, "R2");
      wr_mode(0, "R10");
      wr_mode(1, "R10");
      for (int i = 0; i < run_len(fq_sel); i++) conv(12'sd40, "R4");
      for (int i = 0; i < 7; i++) conv(-12'sd30, "R7");
      conv(12'sd50, "R4");
      host(0, "R5");
      for (int i = 0; i < run_len(fq_sel); i++) conv(-12'sd25, "R6");
      host(1, "R5");
      for (int i = 0; i < run_len(fq_sel); i++) conv(12'sd45, "R6");
      set_pol(1);
      host(2, "R5");
      conv(12'sd45, "R6");
      wr_mode(1, "R10");
      set_pol(0);
    end

    // mixed random operation sequence
    gcr("R9");
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic signed [11:0] tv;
      rs = nxt(rs);
      op = int'(rs[3:0]);
      case (rs[7:5])
        3'd0: tv = lim_lo - 12'sd1;
        3'd1: tv = lim_lo;
        3'd2: tv = lim_hi - 12'sd1;
        3'd3: tv = lim_hi;
        3'd4: tv = lim_hi + 12'sd1;
        default: tv = 12'(rs[31:20]);
      endcase
      if (op < 10) conv(tv, m_mode ? "R6" : "R2");
      else if (op == 10) host(0, "R5");
      else if (op == 11) host(1, "R5");
      else if (op == 12) host(2, "R5");
      else if (op == 13) wr_mode(rs[8], "R10");
      else if (op == 14) begin
        if (rs[9:8] == 2'd0) gcr("R9");
        else begin
          fq_sel = rs[11:10];
          conv(tv, "R3");
        end
      end else begin
        if (rs[12]) set_pol(rs[13]);
        else begin
          lim_hi = 12'(rs[27:16]);
          lim_lo = 12'(rs[27:16]) - 12'(rs[21:16]);
          conv(tv, "R1");
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule